// File: doc/BRIEF.md
# Buffered Serial Peripheral Master

This block is a bus-attached serial peripheral master for 8-bit words. Software talks to it through three word registers: control/status, clock divider and a data port. Each write to the data port pushes one byte into a 16-entry transmit queue. Each read of the data port pops one byte from a 16-entry receive queue. While the run bit is set, a shift engine takes bytes from the transmit queue and serialises them MSB first. It supports all four clock polarity/phase combinations and samples one incoming bit per outgoing bit. Every received byte goes into the receive queue.

Each byte occupies nine serial clock periods: eight data periods followed by one idle period. Consecutive bytes follow with no further gap. The half-period of the serial clock is the divider with its LSB dropped, counted in system clocks. A result of zero gives the slowest rate. Three chip-select lines are driven from a 2-bit selector, and code 3 selects none. A global polarity bit together with a per-line bit turns a line active-high. Two interrupt sources, each with its own enable, share one request line. The first is a receive queue holding 12 or more bytes. The second is the all-sent condition. A three-wire mode releases the data-out pad and samples the shared line instead of the input pin.

Register map (addresses on `reg_addr`): 0 = control/status, 1 = divider, 2 = data port, 3 reads zero. Control bits are writable and read back: [1:0] chip-select code, [2] phase, [3] clock polarity, [6] global CS polarity, [7] run, [8] all-sent interrupt enable, [9] receive-threshold interrupt enable, [10] three-wire read, [13:11] per-line CS polarity for lines 2..0. Bits [4] and [5] are write-one strobes that empty the transmit and receive queues respectively, and they read as zero. Status bits are read-only: [16] all-sent, [17] receive queue non-empty, [18] transmit queue has room, [19] receive count at or above threshold, [20] receive queue full, [21] transmit queue empty.

Top module: `spim_top`

## Requirements
- R1: After reset, address 0 reads 0x0024_0000, all chip-select lines are high, the serial clock is low, `mosi_oe` is 1 and `irq` is 0.
- R2: Bytes written to address 2 are returned by reads of address 2 in the same order, one byte per access. With the data line looped back, the received byte equals the sent byte in every mode.
- R3: The half-period H equals divider[15:1] system clocks, with 0 meaning 32768. A byte written while running and idle starts on the next clock and ends 18·H clocks later, so the all-sent flag rises 1+18·H clocks after the write. A queued next byte follows with no gap.
- R4: While idle the serial clock rests at the polarity bit. With phase 0, bit 7 is on `mosi_o` before the first clock edge. With phase 1, the pin is unchanged until the first (leading) edge, and bit 7 appears there.
- R5: Status bit 16 is 1 exactly when run is set, the transmit queue is empty and the shifter is idle. Setting run with an empty queue raises it at once, and clearing run stops the shifter.
- R6: Status bits 17, 18, 19, 20 and 21 report receive non-empty, transmit room, receive count ≥ 12, receive full and transmit empty.
- R7: No byte starts while the receive queue is full. The stalled bytes stay in the transmit queue and are sent after reads make room, and no received byte is lost.
- R8: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue.
- R9: Line k is asserted while run is set and the code equals k. Its asserted level is 1 when both bit 6 and its per-line bit are set, and 0 otherwise. A deasserted line sits at the opposite level, and code 3 asserts no line.
- R10: `irq` is 1 when (bit 8 and status bit 16) or (bit 9 and status bit 19).
- R11: In three-wire mode `mosi_oe` is 0 and received bits come from `mosi_i`, not `miso_i`.
- R12: A write to a full transmit queue is dropped, and a data read from an empty receive queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the receive queue at address 2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out pad |
| mosi_i | input | 1 | Pad readback of the shared data line (three-wire) |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines |

## Verification
A wrong half-tick count or a missed idle period shows as a shift in the all-sent edge, so timing the `irq` rise after a data write exposes it within one byte. A wrong phase decision shows as the wrong level on `mosi_o` before or at the first clock edge, which is visible two system clocks after the write. A wrong bit order or sampling edge corrupts the looped-back byte on the very next data read. Queue pointer or count errors appear as reordered or missing bytes, or as wrong threshold, full and empty flags, when a full queue is drained.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int CS_LINES = 3;
    localparam int CSEL_W   = 2;
    localparam int BYTE_W   = 8;

    // control register bit positions
    localparam int B_CSEL   = 0;
    localparam int B_PHASE  = 2;
    localparam int B_POL    = 3;
    localparam int B_CLRTX  = 4;
    localparam int B_CLRRX  = 5;
    localparam int B_GPOL   = 6;
    localparam int B_RUN    = 7;
    localparam int B_IEDONE = 8;
    localparam int B_IERX   = 9;
    localparam int B_WIRE3  = 10;
    localparam int B_LPOL   = 11;

    // status bit positions
    localparam int S_DONE   = 16;
    localparam int S_RXANY  = 17;
    localparam int S_TXROOM = 18;
    localparam int S_RXTHR  = 19;
    localparam int S_RXFULL = 20;
    localparam int S_TXMT   = 21;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DIV  = 2'd1,
        A_DATA = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CS_LINES-1:0] lpol;
        logic                wire3;
        logic                ie_rx;
        logic                ie_done;
        logic                run;
        logic                gpol;
        logic                pol;
        logic                phase;
        logic [CSEL_W-1:0]   csel;
    } ctrl_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    // DEPTH must be a power of two so that the pointers wrap naturally
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign rdata = mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = q.wp + 1'b1;
            if (do_pop)  d.rp = q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[q.wp] <= wdata;
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
    parameter int DIV_W = 16,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_i,
    input  logic                   pol_i,
    input  logic                   phase_i,
    input  logic                   wire3_i,
    input  logic [DIV_W-1:0]       div_i,
    input  logic                   tx_valid_i,
    input  logic [7:0]             tx_byte_i,
    output logic                   tx_pop_o,
    input  logic [$clog2(DEPTH):0] rx_cnt_i,
    output logic                   rx_push_o,
    output logic [7:0]             rx_byte_o,
    output logic                   busy_o,
    output logic                   sck_o,
    output logic                   sdo_o,
    output logic                   sdo_oe_o,
    input  logic                   sdio_i,
    input  logic                   sdi_i
);
    localparam int CW        = $clog2(DEPTH) + 1;
    localparam int HALVES    = 18;            // 9 serial periods per byte
    localparam int DATA_HALF = 16;            // first 8 periods carry data

    typedef struct packed {
        logic             busy;
        logic [4:0]       hc;
        logic [DIV_W-1:0] dc;
        logic [7:0]       txs;
        logic [7:0]       rxs;
        logic             sdo;
    } eng_t;

    eng_t q, d;
    logic [DIV_W-1:0] hp, hp_m1;
    logic tick, lead, trail, sbit, room_now, room_next;

    function automatic eng_t load_byte(input eng_t cur, input logic [7:0] b, input logic ph);
        eng_t r;
        r      = cur;
        r.busy = 1'b1;
        r.hc   = '0;
        r.dc   = '0;
        if (!ph) begin
            r.sdo = b[7];
            r.txs = {b[6:0], 1'b0};
        end else begin
            r.txs = b;
        end
        return r;
    endfunction

    always_comb begin
        hp = {1'b0, div_i[DIV_W-1:1]};
        if (hp == '0) hp = {1'b1, {(DIV_W-1){1'b0}}};
        hp_m1     = hp - 1'b1;
        tick      = q.busy && (q.dc == hp_m1);
        lead      = tick && !q.hc[0] && (q.hc < 5'(DATA_HALF));
        trail     = tick &&  q.hc[0] && (q.hc < 5'(DATA_HALF));
        sbit      = wire3_i ? sdio_i : sdi_i;
        room_now  = rx_cnt_i < CW'(DEPTH);
        room_next = rx_cnt_i < CW'(DEPTH - 1);

        d         = q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;

        if (!run_i) begin
            d.busy = 1'b0;
            d.hc   = '0;
            d.dc   = '0;
        end else if (!q.busy) begin
            if (tx_valid_i && room_now) begin
                d        = load_byte(q, tx_byte_i, phase_i);
                tx_pop_o = 1'b1;
            end
        end else begin
            d.dc = tick ? '0 : q.dc + 1'b1;
            if (lead) begin
                if (!phase_i) begin
                    d.rxs = {q.rxs[6:0], sbit};
                end else begin
                    d.sdo = q.txs[7];
                    d.txs = {q.txs[6:0], 1'b0};
                end
            end
            if (trail) begin
                if (!phase_i) begin
                    d.sdo = q.txs[7];
                    d.txs = {q.txs[6:0], 1'b0};
                end else begin
                    d.rxs = {q.rxs[6:0], sbit};
                end
            end
            if (tick) begin
                if (q.hc == 5'(HALVES - 1)) begin
                    rx_push_o = 1'b1;
                    d.busy    = 1'b0;
                    d.hc      = '0;
                    if (tx_valid_i && room_next) begin
                        d        = load_byte(d, tx_byte_i, phase_i);
                        tx_pop_o = 1'b1;
                    end
                end else begin
                    d.hc = q.hc + 5'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte_o = q.rxs;
    assign busy_o    = q.busy;
    assign sck_o     = pol_i ^ (q.busy && q.hc[0] && (q.hc < 5'(DATA_HALF)));
    assign sdo_o     = q.sdo;
    assign sdo_oe_o  = !wire3_i;

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RX_THRESH  = 12,
    parameter int DIV_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq,
    output logic                sck_o,
    output logic                mosi_o,
    output logic                mosi_oe,
    input  logic                mosi_i,
    input  logic                miso_i,
    output logic [CS_LINES-1:0] cs_o
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t r_q, r_d;
    logic flush_tx, flush_rx, tx_push, rx_pop;
    logic tx_pop, rx_push, busy, done, rx_thr;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0] tx_head, rx_head, rx_byte;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic run_on, pol_idle;
    logic unused_wbits;
    reg_addr_e a;

    assign unused_wbits = ^{reg_wdata[31:14], tx_cnt};
    assign a = reg_addr_e'(reg_addr);

    // register next-state
    always_comb begin
        r_d      = r_q;
        flush_tx = 1'b0;
        flush_rx = 1'b0;
        tx_push  = 1'b0;
        rx_pop   = reg_rd && (a == A_DATA);
        if (reg_wr) begin
            case (a)
                A_CTRL: begin
                    r_d.ctrl.csel    = reg_wdata[B_CSEL +: CSEL_W];
                    r_d.ctrl.phase   = reg_wdata[B_PHASE];
                    r_d.ctrl.pol     = reg_wdata[B_POL];
                    r_d.ctrl.gpol    = reg_wdata[B_GPOL];
                    r_d.ctrl.run     = reg_wdata[B_RUN];
                    r_d.ctrl.ie_done = reg_wdata[B_IEDONE];
                    r_d.ctrl.ie_rx   = reg_wdata[B_IERX];
                    r_d.ctrl.wire3   = reg_wdata[B_WIRE3];
                    r_d.ctrl.lpol    = reg_wdata[B_LPOL +: CS_LINES];
                    flush_tx         = reg_wdata[B_CLRTX];
                    flush_rx         = reg_wdata[B_CLRRX];
                end
                A_DIV:   r_d.div = reg_wdata[DIV_W-1:0];
                A_DATA:  tx_push = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done   = r_q.ctrl.run && tx_empty && !busy;
    assign rx_thr = rx_cnt >= CW'(RX_THRESH);
    assign irq    = (r_q.ctrl.ie_done && done) || (r_q.ctrl.ie_rx && rx_thr);
    assign run_on   = r_q.ctrl.run;
    assign pol_idle = r_q.ctrl.pol;

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (a)
            A_CTRL: begin
                reg_rdata[B_CSEL +: CSEL_W]   = r_q.ctrl.csel;
                reg_rdata[B_PHASE]            = r_q.ctrl.phase;
                reg_rdata[B_POL]              = r_q.ctrl.pol;
                reg_rdata[B_GPOL]             = r_q.ctrl.gpol;
                reg_rdata[B_RUN]              = r_q.ctrl.run;
                reg_rdata[B_IEDONE]           = r_q.ctrl.ie_done;
                reg_rdata[B_IERX]             = r_q.ctrl.ie_rx;
                reg_rdata[B_WIRE3]            = r_q.ctrl.wire3;
                reg_rdata[B_LPOL +: CS_LINES] = r_q.ctrl.lpol;
                reg_rdata[S_DONE]             = done;
                reg_rdata[S_RXANY]            = !rx_empty;
                reg_rdata[S_TXROOM]           = !tx_full;
                reg_rdata[S_RXTHR]            = rx_thr;
                reg_rdata[S_RXFULL]           = rx_full;
                reg_rdata[S_TXMT]             = tx_empty;
            end
            A_DIV:   reg_rdata[DIV_W-1:0] = r_q.div;
            A_DATA:  reg_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
            default: reg_rdata = '0;
        endcase
    end

    // chip-select lines
    for (genvar k = 0; k < CS_LINES; k++) begin : g_cs
        logic hi, sel;
        assign hi      = r_q.ctrl.gpol && r_q.ctrl.lpol[k];
        assign sel     = r_q.ctrl.run && (r_q.ctrl.csel == CSEL_W'(k));
        assign cs_o[k] = sel ? hi : !hi;
    end

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .push(tx_push), .wdata(reg_wdata[7:0]), .pop(tx_pop),
        .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
        .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.DIV_W(DIV_W), .DEPTH(FIFO_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .run_i(r_q.ctrl.run), .pol_i(r_q.ctrl.pol), .phase_i(r_q.ctrl.phase),
        .wire3_i(r_q.ctrl.wire3), .div_i(r_q.div),
        .tx_valid_i(!tx_empty), .tx_byte_i(tx_head), .tx_pop_o(tx_pop),
        .rx_cnt_i(rx_cnt), .rx_push_o(rx_push), .rx_byte_o(rx_byte),
        .busy_o(busy), .sck_o(sck_o), .sdo_o(mosi_o), .sdo_oe_o(mosi_oe),
        .sdio_i(mosi_i), .sdi_i(miso_i)
    );

endmodule

// File: rtl/spim_chk.sv
module spim_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic pol,
    input logic sck,
    input logic busy,
    input logic tx_pop,
    input logic tx_empty,
    input logic rx_push,
    input logic rx_full,
    input logic flush_tx
);
    // R2: the shifter never takes a byte from an empty transmit queue
    assert_no_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    // R7: a received byte is never pushed into a full receive queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    // R5: clearing run leaves the shifter idle on the next cycle
    assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !busy);

    // R4: an idle shifter holds the serial clock at its polarity level
    assert_sck_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == pol));

    // R3: bytes complete only while the shifter is active
    assert_push_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> busy);

    // R8: an emptying strobe leaves the transmit queue empty
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx |=> tx_empty);

endmodule

bind spim_top spim_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_on), .pol(pol_idle), .sck(sck_o),
    .busy(busy), .tx_pop(tx_pop), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_full(rx_full), .flush_tx(flush_tx)
);

// File: tb/sim_spim_top.sv
module sim_spim_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sck_o, mosi_o, mosi_oe, miso_i;
    logic        mosi_i = 1'b0;
    logic [2:0]  cs_o;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign miso_i = mosi_o;  // loopback

    spim_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .mosi_i(mosi_i), .miso_i(miso_i), .cs_o(cs_o)
    );

    // {pol, phase, divider, byte, cycles from write to all-sent}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b0, 16'd2, 8'hA5, 8'd19},
        {1'b0, 1'b1, 16'd2, 8'h3C, 8'd19},
        {1'b1, 1'b0, 16'd2, 8'h81, 8'd19},
        {1'b1, 1'b1, 16'd2, 8'h5A, 8'd19},
        {1'b0, 1'b0, 16'd3, 8'hC3, 8'd19},
        {1'b1, 1'b1, 16'd6, 8'h96, 8'd55}
    };

    function automatic logic [31:0] ctl(input logic [1:0] csel, input logic ph,
        input logic pl, input logic ctx, input logic crx, input logic gp,
        input logic rn, input logic ied, input logic ier, input logic w3,
        input logic [2:0] lp);
        return {18'b0, lp, w3, ier, ied, rn, gp, crx, ctx, pl, ph, csel};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] dat);
        reg_addr = a; reg_wdata = dat; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 5000);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v);
        check("R1 status", v, 32'h0024_0000);
        check("R1 cs", {29'b0, cs_o}, 32'h7);
        check("R1 sck", {31'b0, sck_o}, 32'h0);
        check("R1 oe", {31'b0, mosi_oe}, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // vector table: modes and dividers, loopback (R2 R3 R4 R5 R9 R10)
        for (int i = 0; i < 6; i++) begin
            wr(2'd1, {16'b0, VEC[i][31:16]});
            wr(2'd0, ctl(2'd0, VEC[i][32], VEC[i][33], 0, 0, 0, 1, 1, 0, 0, 3'b000));
            check("R4 idle sck", {31'b0, sck_o}, {31'b0, VEC[i][33]});
            check("R5 done at run", {31'b0, irq}, 32'h1);
            check("R9 cs line0", {29'b0, cs_o}, 32'h6);
            wr(2'd2, {24'b0, VEC[i][15:8]});
            wait_irq(n);
            check("R3 byte cycles", n, {24'b0, VEC[i][7:0]});
            rd(2'd2, v);
            check("R2 loopback", v, {24'b0, VEC[i][15:8]});
        end

        // R3 back-to-back: two bytes, 36 cycles after the second write
        wr(2'd1, 32'd2);
        wr(2'd0, ctl(2'd0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 3'b000));
        wr(2'd2, 32'h11);
        wr(2'd2, 32'h22);
        wait_irq(n);
        check("R3 no gap", n, 32'd36);
        rd(2'd2, v); check("R2 order 1st", v, 32'h11);
        rd(2'd2, v); check("R2 order 2nd", v, 32'h22);

        // R4 phase 0: bit 7 before the first edge
        wr(2'd1, 32'd4);
        wr(2'd2, 32'h80);
        idle(1);
        check("R4 ph0 early data", {31'b0, mosi_o}, 32'h1);
        check("R4 ph0 sck idle", {31'b0, sck_o}, 32'h0);
        idle(2);
        check("R4 ph0 lead edge", {31'b0, sck_o}, 32'h1);
        wait_irq(n);
        rd(2'd2, v);
        // R4 phase 1: bit 7 only at the leading edge
        wr(2'd0, ctl(2'd0, 1, 0, 0, 0, 0, 1, 1, 0, 0, 3'b000));
        wr(2'd2, 32'h80);
        idle(1);
        check("R4 ph1 held data", {31'b0, mosi_o}, 32'h0);
        idle(2);
        check("R4 ph1 lead sck", {31'b0, sck_o}, 32'h1);
        check("R4 ph1 lead data", {31'b0, mosi_o}, 32'h1);
        wait_irq(n);
        rd(2'd2, v);
        check("R2 ph1 loopback", v, 32'h80);

        // R11 three-wire read
        wr(2'd1, 32'd2);
        mosi_i = 1'b1;
        wr(2'd0, ctl(2'd0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 3'b000));
        check("R11 oe off", {31'b0, mosi_oe}, 32'h0);
        wr(2'd2, 32'h00);
        wait_irq(n);
        rd(2'd2, v);
        check("R11 shared line", v, 32'hFF);
        mosi_i = 1'b0;

        // R9 chip-select codes and polarity
        wr(2'd0, ctl(2'd1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 3'b000));
        check("R9 line1 low", {29'b0, cs_o}, 32'h5);
        wr(2'd0, ctl(2'd3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 3'b000));
        check("R9 code3 none", {29'b0, cs_o}, 32'h7);
        wr(2'd0, ctl(2'd2, 0, 0, 0, 0, 1, 1, 0, 0, 0, 3'b010));
        check("R9 mixed polarity", {29'b0, cs_o}, 32'h1);
        wr(2'd0, ctl(2'd2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 3'b010));
        check("R9 deselected", {29'b0, cs_o}, 32'h5);

        // R12 R6: fill the transmit queue while stopped
        wr(2'd0, ctl(2'd0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 3'b000));
        for (int i = 0; i < 16; i++) wr(2'd2, 32'h10 + i);
        rd(2'd0, v);
        check("R6 tx no room", {31'b0, v[18]}, 32'h0);
        check("R6 tx not empty", {31'b0, v[21]}, 32'h0);
        wr(2'd2, 32'hEE);
        wr(2'd0, ctl(2'd0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 3'b000));
        idle(320);
        rd(2'd0, v);
        check("R6 rx full", {31'b0, v[20]}, 32'h1);
        check("R6 rx thr", {31'b0, v[19]}, 32'h1);
        check("R5 done", {31'b0, v[16]}, 32'h1);
        check("R10 thr irq", {31'b0, irq}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(2'd2, v);
            check("R12 R2 order", v, 32'h10 + i);
            if (i == 3) begin
                rd(2'd0, v);
                check("R6 thr at 12", {31'b0, v[19]}, 32'h1);
            end
            if (i == 4) begin
                rd(2'd0, v);
                check("R6 thr at 11", {31'b0, v[19]}, 32'h0);
                check("R10 irq off", {31'b0, irq}, 32'h0);
            end
        end
        rd(2'd0, v);
        check("R6 rx empty", {31'b0, v[17]}, 32'h0);
        rd(2'd2, v);
        check("R12 empty read", v, 32'h0);

        // R7 stall while the receive queue is full
        for (int i = 0; i < 16; i++) wr(2'd2, 32'h20 + i);
        idle(330);
        wr(2'd2, 32'h55);
        wr(2'd2, 32'h66);
        idle(100);
        rd(2'd0, v);
        check("R7 tx held", {31'b0, v[21]}, 32'h0);
        check("R7 not done", {31'b0, v[16]}, 32'h0);
        rd(2'd2, v);
        check("R7 first out", v, 32'h20);
        idle(40);
        rd(2'd0, v);
        check("R7 one left", {31'b0, v[21]}, 32'h0);
        check("R7 full again", {31'b0, v[20]}, 32'h1);

        // R8 empty the transmit queue
        wr(2'd0, ctl(2'd0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 3'b000));
        rd(2'd0, v);
        check("R8 tx emptied", {31'b0, v[21]}, 32'h1);
        check("R8 R5 done", {31'b0, v[16]}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(2'd2, v);
            check("R7 no loss", v, (i < 15) ? 32'h21 + i : 32'h55);
        end

        // R8 empty the receive queue
        wr(2'd2, 32'h77);
        idle(30);
        rd(2'd0, v);
        check("R8 rx has byte", {31'b0, v[17]}, 32'h1);
        wr(2'd0, ctl(2'd0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 3'b000));
        rd(2'd0, v);
        check("R8 rx emptied", {31'b0, v[17]}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule